// File: doc/BRIEF.md
# Dual-Clock FIFO with Error Flags

This block is a first-in first-out buffer whose write side and read side run on two unrelated clocks. Words enter on the write clock whenever write enable is high and the buffer has room. They leave on the read clock, one cycle after a read request is accepted, and appear on a registered data output. Both pointers are one bit wider than the memory address. Each pointer crosses to the other domain as Gray code through a two-flop synchroniser. Empty is produced in the read domain and full in the write domain.

Two programmable thresholds give early warnings. Almost empty rises when the occupancy seen by the reader is at or below its level. Almost full rises when the free space seen by the writer is at or below its level. A request the buffer cannot honour is refused without side effects. It is reported one edge later on a registered error output for that side: a read while empty, or a write while full. The error output is re-evaluated on every edge of its own clock.

One active-low reset clears both domains asynchronously and is released synchronously in each domain. It must be held low for at least three cycles of both clocks.

Top module: `xclk_fifo`

## Requirements
- R1: While `arst_n` is low, `empty` and `almost_empty` are 1, and `full`, `almost_full`, `wr_err` and `rd_err` are 0, without waiting for a clock edge.
- R2: Words leave in the order they were accepted. `rd_data` takes the next word on the first read-clock edge at which `rd_en` is 1 and `empty` is 0.
- R3: On every read-clock edge, `rd_err` is loaded with (`rd_en` AND `empty`). It stays high while both hold and falls on the first edge after `rd_en` drops.
- R4: A read request while `empty` is 1 leaves `rd_data` unchanged, still holding the last word read (0 after reset).
- R5: On every write-clock edge, `wr_err` is loaded with (`wr_en` AND `full`).
- R6: A write request while `full` is 1 changes neither the stored words nor the write pointer, so later reads never return the refused word.
- R7: Flags never lie in the unsafe direction. `empty` is 0 only when data is stored, and `full` is 0 only when space is free. Each Gray pointer changes by at most one bit per edge.
- R8: Once both sides have been idle for eight cycles of each clock, `empty` is 1 exactly when the buffer holds no words. `full` is 1 exactly when it holds DEPTH = 2**ADDR_W words.
- R9: Once idle as in R8, `almost_empty` is 1 exactly when occupancy ≤ AE_LEVEL. `empty` implies `almost_empty` at all times.
- R10: Once idle as in R8, `almost_full` is 1 exactly when (DEPTH − occupancy) ≤ AF_LEVEL. `full` implies `almost_full` at all times.
- R11: A reset applied while data is stored discards that data. After release the buffer is empty and accepts new traffic normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock, unrelated to wr_clk |
| arst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to write |
| full | output | 1 | No free space (write domain) |
| almost_full | output | 1 | Free space ≤ AF_LEVEL |
| wr_err | output | 1 | Previous write-clock edge saw a write while full |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Last word read, registered |
| empty | output | 1 | No stored words (read domain) |
| almost_empty | output | 1 | Occupancy ≤ AE_LEVEL |
| rd_err | output | 1 | Previous read-clock edge saw a read while empty |

## Verification
The assertions assume that `wr_en`, `wr_data` and `rd_en` are synchronous to their own clocks. They also assume that `arst_n` stays low for at least three cycles of each clock. The stimulus changes inputs only on the falling edge of the matching clock. Before each reset it stops all requests, holds reset low for four cycles of both clocks, and waits four more cycles after release before resuming traffic.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;
  // number of flops in every clock-crossing and reset-release chain
  localparam int unsigned SYNC_STAGES = 2;
  // idle cycles (per clock) after which the flags are exact
  localparam int unsigned SETTLE_CYCLES = 8;

  function automatic int unsigned ptr_width(int unsigned aw);
    return aw + 1;
  endfunction
endpackage

// File: rtl/xfifo_rst_sync.sv
module xfifo_rst_sync #(
  parameter int unsigned STAGES = xfifo_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_n;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/xfifo_sync.sv
module xfifo_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = xfifo_pkg::SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/xfifo_mem.sv
module xfifo_mem #(
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] ram [DEPTH];
  logic [DW-1:0] rdata_q;
  logic [DW-1:0] rdata_n;

  always_ff @(posedge wclk) begin
    if (we) ram[waddr] <= wdata;
  end

  always_comb begin
    rdata_n = rdata_q;
    if (re) rdata_n = ram[raddr];
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) rdata_q <= '0;
    else         rdata_q <= rdata_n;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/xfifo_wside.sv
module xfifo_wside #(
  parameter int unsigned AW       = 4,
  parameter int unsigned AF_LEVEL = 2,
  localparam int unsigned PW      = xfifo_pkg::ptr_width(AW)
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] rgray_s,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic          full,
  output logic          afull,
  output logic          wr_err
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [PW-1:0] wbin_q, wbin_n;
  logic [PW-1:0] wgray_q, wgray_n;
  logic [PW-1:0] rbin_s, used, free;
  logic          full_q, full_n, afull_q, afull_n, err_q, err_n;

  always_comb begin
    we      = wr_en & ~full_q;
    wbin_n  = wbin_q + PW'(we);
    wgray_n = wbin_n ^ (wbin_n >> 1);
    rbin_s[PW-1] = rgray_s[PW-1];
    for (int i = PW - 2; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
    used    = wbin_n - rbin_s;
    free    = PW'(DEPTH) - used;
    full_n  = (used == PW'(DEPTH));
    afull_n = (free <= PW'(AF_LEVEL));
    err_n   = wr_en & full_q;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
      afull_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      wbin_q  <= wbin_n;
      wgray_q <= wgray_n;
      full_q  <= full_n;
      afull_q <= afull_n;
      err_q   <= err_n;
    end
  end

  assign waddr  = wbin_q[AW-1:0];
  assign wgray  = wgray_q;
  assign full   = full_q;
  assign afull  = afull_q;
  assign wr_err = err_q;

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wr_en && full) |=> $stable(wbin_q)); // R6
  AST_WRERR_CAUSE: assert property (@(posedge wclk) disable iff (!wrst_n)
    wr_err |-> $past(wr_en && full)); // R5
  AST_FULL_AFULL: assert property (@(posedge wclk) disable iff (!wrst_n)
    full |-> afull); // R10
  AST_WGRAY_STEP: assert property (@(posedge wclk) disable iff (!wrst_n)
    1'b1 |=> ($countones(wgray_q ^ $past(wgray_q)) <= 1)); // R7
endmodule

// File: rtl/xfifo_rside.sv
module xfifo_rside #(
  parameter int unsigned AW       = 4,
  parameter int unsigned AE_LEVEL = 2,
  localparam int unsigned PW      = xfifo_pkg::ptr_width(AW)
) (
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_en,
  input  logic [PW-1:0] wgray_s,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic          empty,
  output logic          aempty,
  output logic          rd_err
);
  logic [PW-1:0] rbin_q, rbin_n;
  logic [PW-1:0] rgray_q, rgray_n;
  logic [PW-1:0] wbin_s, occ;
  logic          empty_q, empty_n, aempty_q, aempty_n, err_q, err_n;

  always_comb begin
    re       = rd_en & ~empty_q;
    rbin_n   = rbin_q + PW'(re);
    rgray_n  = rbin_n ^ (rbin_n >> 1);
    wbin_s[PW-1] = wgray_s[PW-1];
    for (int i = PW - 2; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
    occ      = wbin_s - rbin_n;
    empty_n  = (rgray_n == wgray_s);
    aempty_n = (occ <= PW'(AE_LEVEL));
    err_n    = rd_en & empty_q;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q   <= '0;
      rgray_q  <= '0;
      empty_q  <= 1'b1;
      aempty_q <= 1'b1;
      err_q    <= 1'b0;
    end else begin
      rbin_q   <= rbin_n;
      rgray_q  <= rgray_n;
      empty_q  <= empty_n;
      aempty_q <= aempty_n;
      err_q    <= err_n;
    end
  end

  assign raddr  = rbin_q[AW-1:0];
  assign rgray  = rgray_q;
  assign empty  = empty_q;
  assign aempty = aempty_q;
  assign rd_err = err_q;

  AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_en && empty) |=> $stable(rbin_q)); // R7
  AST_RDERR_CAUSE: assert property (@(posedge rclk) disable iff (!rrst_n)
    rd_err |-> $past(rd_en && empty)); // R3
  AST_EMPTY_AEMPTY: assert property (@(posedge rclk) disable iff (!rrst_n)
    empty |-> aempty); // R9
  AST_RGRAY_STEP: assert property (@(posedge rclk) disable iff (!rrst_n)
    1'b1 |=> ($countones(rgray_q ^ $past(rgray_q)) <= 1)); // R7
endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned AE_LEVEL = 2,
  parameter int unsigned AF_LEVEL = 2
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              arst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              full,
  output logic              almost_full,
  output logic              wr_err,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty,
  output logic              almost_empty,
  output logic              rd_err
);
  localparam int unsigned PW = xfifo_pkg::ptr_width(ADDR_W);

  logic              wrst_n, rrst_n;
  logic              we, re;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;

  xfifo_rst_sync u_wrst (.clk(wr_clk), .arst_n(arst_n), .rst_n_o(wrst_n));
  xfifo_rst_sync u_rrst (.clk(rd_clk), .arst_n(arst_n), .rst_n_o(rrst_n));

  xfifo_sync #(.W(PW)) u_r2w (.clk(wr_clk), .rst_n(wrst_n), .d(rgray), .q(rgray_s));
  xfifo_sync #(.W(PW)) u_w2r (.clk(rd_clk), .rst_n(rrst_n), .d(wgray), .q(wgray_s));

  xfifo_wside #(.AW(ADDR_W), .AF_LEVEL(AF_LEVEL)) u_wside (
    .wclk(wr_clk), .wrst_n(wrst_n), .wr_en(wr_en), .rgray_s(rgray_s),
    .we(we), .waddr(waddr), .wgray(wgray), .full(full),
    .afull(almost_full), .wr_err(wr_err)
  );

  xfifo_rside #(.AW(ADDR_W), .AE_LEVEL(AE_LEVEL)) u_rside (
    .rclk(rd_clk), .rrst_n(rrst_n), .rd_en(rd_en), .wgray_s(wgray_s),
    .re(re), .raddr(raddr), .rgray(rgray), .empty(empty),
    .aempty(almost_empty), .rd_err(rd_err)
  );

  xfifo_mem #(.DW(DATA_W), .AW(ADDR_W)) u_mem (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .rclk(rd_clk), .rrst_n(rrst_n), .re(re), .raddr(raddr), .rdata(rd_data)
  );

  AST_DOUT_HOLD: assert property (@(posedge rd_clk) disable iff (!rrst_n)
    (rd_en && empty) |=> $stable(rd_data)); // R4
endmodule

// File: tb/xclk_fifo_bench.sv
`timescale 1ns/1ps
module xclk_fifo_bench;
  localparam int DW = 8, AW = 4, DEPTH = 1 << AW, AE = 2, AF = 2;

  logic wr_clk = 1'b0, rd_clk = 1'b0, arst_n = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic full, almost_full, wr_err, empty, almost_empty, rd_err;
  logic [DW-1:0] rd_data;

  always #10   wr_clk = ~wr_clk;   // 50 MHz
  always #13.7 rd_clk = ~rd_clk;   // unrelated read clock

  xclk_fifo #(.DATA_W(DW), .ADDR_W(AW), .AE_LEVEL(AE), .AF_LEVEL(AF)) u_xclk_fifo (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .arst_n(arst_n),
    .wr_en(wr_en), .wr_data(wr_data), .full(full), .almost_full(almost_full),
    .wr_err(wr_err), .rd_en(rd_en), .rd_data(rd_data), .empty(empty),
    .almost_empty(almost_empty), .rd_err(rd_err)
  );

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] model_q[$];
  bit in_rst = 1'b1, paused = 1'b1;
  int w_prob = 0, r_prob = 0, w_budget = -1, r_budget = -1;
  bit w_valid = 1'b0, r_valid = 1'b0, exp_wr_err = 1'b0, exp_rd_err = 1'b0, exp_pop = 1'b0;
  logic [DW-1:0] exp_dout = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // write-side reference model, one step per write clock
  always @(negedge wr_clk) begin
    if (in_rst) begin
      wr_en <= 1'b0; w_valid <= 1'b0;
    end else begin
      if (w_valid) chk(wr_err == exp_wr_err, "R5 wr_err", int'(wr_err), int'(exp_wr_err));
      if (!full) chk(model_q.size() < DEPTH, "R7 not-full with no space", model_q.size(), DEPTH - 1);
      if (!paused && w_budget != 0 && $urandom_range(99) < w_prob) begin
        logic [DW-1:0] d;
        d = DW'($urandom);
        wr_en <= 1'b1; wr_data <= d;
        exp_wr_err <= full;
        if (!full) begin
          model_q.push_back(d);
          if (w_budget > 0) w_budget <= w_budget - 1;
        end
      end else begin
        wr_en <= 1'b0; exp_wr_err <= 1'b0;
      end
      w_valid <= 1'b1;
    end
  end

  // read-side reference model, one step per read clock
  always @(negedge rd_clk) begin
    if (in_rst) begin
      rd_en <= 1'b0; r_valid <= 1'b0;
    end else begin
      if (r_valid) begin
        chk(rd_err == exp_rd_err, "R3 rd_err", int'(rd_err), int'(exp_rd_err));
        if (exp_pop) chk(rd_data == exp_dout, "R2 order", int'(rd_data), int'(exp_dout));
        else         chk(rd_data == exp_dout, "R4 hold", int'(rd_data), int'(exp_dout));
      end
      if (!empty) chk(model_q.size() > 0, "R7 not-empty with no data", model_q.size(), 1);
      if (!paused && r_budget != 0 && $urandom_range(99) < r_prob) begin
        rd_en <= 1'b1;
        exp_rd_err <= empty;
        exp_pop <= !empty;
        if (!empty) begin
          exp_dout <= model_q.pop_front();
          if (r_budget > 0) r_budget <= r_budget - 1;
        end
      end else begin
        rd_en <= 1'b0; exp_rd_err <= 1'b0; exp_pop <= 1'b0;
      end
      r_valid <= 1'b1;
    end
  end

  task automatic settle_and_check(input string tag);
    int n;
    paused = 1'b1;
    repeat (8) @(negedge rd_clk);
    repeat (8) @(negedge wr_clk);
    n = model_q.size();
    @(negedge rd_clk);
    chk(empty == (n == 0), {"R8 empty ", tag}, int'(empty), int'(n == 0));
    chk(almost_empty == (n <= AE), {"R9 almost_empty ", tag}, int'(almost_empty), int'(n <= AE));
    @(negedge wr_clk);
    chk(full == (n == DEPTH), {"R8 full ", tag}, int'(full), int'(n == DEPTH));
    chk(almost_full == (DEPTH - n <= AF), {"R10 almost_full ", tag}, int'(almost_full), int'(DEPTH - n <= AF));
  endtask

  task automatic check_reset_flags(input string tag);
    chk(empty && almost_empty, {"R1 empty flags ", tag}, int'({empty, almost_empty}), 3);
    chk(!full && !almost_full, {"R1 full flags ", tag}, int'({full, almost_full}), 0);
    chk(!wr_err && !rd_err, {"R1 error flags ", tag}, int'({wr_err, rd_err}), 0);
  endtask

  task automatic apply_reset();
    paused = 1'b1;
    repeat (3) @(negedge wr_clk);
    repeat (3) @(negedge rd_clk);
    in_rst = 1'b1;
    #2 arst_n = 1'b0;
    #1 check_reset_flags("on assert");
    repeat (4) @(posedge wr_clk);
    repeat (4) @(posedge rd_clk);
    check_reset_flags("held");
    model_q.delete();
    exp_dout = '0;
    @(negedge wr_clk) arst_n = 1'b1;
    repeat (4) @(posedge wr_clk);
    repeat (4) @(posedge rd_clk);
    in_rst = 1'b0;
  endtask

  task automatic run_traffic(input int wp, input int rp, input int cycles);
    w_prob = wp; r_prob = rp; w_budget = -1; r_budget = -1;
    paused = 1'b0;
    repeat (cycles) @(negedge wr_clk);
  endtask

  initial begin
    #100_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    apply_reset();
    settle_and_check("after reset");

    // fill past full: refused writes raise wr_err
    run_traffic(100, 0, 3 * DEPTH);
    settle_and_check("filled");
    // drain past empty: rd_err and held data
    w_prob = 0; r_prob = 100; paused = 1'b0;
    repeat (3 * DEPTH) @(negedge rd_clk);
    settle_and_check("drained");

    // step occupancy up one word at a time, then back down
    for (int k = 0; k < DEPTH; k++) begin
      w_prob = 100; r_prob = 0; w_budget = 1; paused = 1'b0;
      wait (w_budget == 0);
      settle_and_check("step up");
    end
    for (int k = 0; k < DEPTH; k++) begin
      w_prob = 0; r_prob = 100; r_budget = 1; paused = 1'b0;
      wait (r_budget == 0);
      settle_and_check("step down");
    end

    run_traffic(70, 30, 1500); settle_and_check("write heavy");
    run_traffic(30, 70, 1500); settle_and_check("read heavy");
    run_traffic(50, 50, 1500); settle_and_check("balanced");

    // R11: reset with data resident
    run_traffic(80, 20, 100);
    apply_reset();
    settle_and_check("R11 after mid reset");
    chk(model_q.size() == 0 && empty, "R11 contents discarded", int'(empty), 1);
    run_traffic(50, 50, 500);
    settle_and_check("R11 traffic after reset");
    run_traffic(0, 100, 3 * DEPTH);
    settle_and_check("final drain");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule